// File: doc/BRIEF.md
# Burst Serial Master with In-Place Buffer

This block is a clocked serial master that moves a burst of up to sixteen 8-bit words through one shared 16-entry buffer. Software programs a burst length and a mode, loads transmit words through a small host register port, and waits for the completion interrupt. In the receive and full-duplex modes, each word shifted in overwrites the buffer entry whose word was just shifted out, so after the burst the same buffer holds the received data. Software then reads that data back through a separate read pointer. Before the next burst, software must clear all the pointers explicitly.

The serial link drives a clock that idles low, a data output and a data input. Words go out MSB first. Output data changes on the falling edge and input data is sampled on the rising edge. Each half period of the serial clock is `CLK_HALF` system cycles.

The host port has three addresses: `2'd0` control, `2'd1` data and `2'd2` status. A host access is a one-cycle write strobe or read strobe together with an address. Read data is combinational from the current state.

Top module: `spim_burst`

## Requirements
- R1: A burst starts (busy, status bit 0, goes to 1) only when control bit 0 (transmit enable) or bit 1 (receive enable) is set and the buffer holds at least one unsent word. While no unsent word is present, busy stays 1, the serial clock stays idle and the position does not move until another word is written.
- R2: Control bits [7:4] hold the burst length, and 0 means 16. A data write is stored only while fewer words than the length have been written since the last pointer clear. Words beyond that are dropped and never shifted out.
- R3: The serial clock idles low and stays high for `CLK_HALF` system cycles per bit. Data leaves MSB first on `mosi_o`, changes only while the clock is low, and `miso_i` is sampled on the rising edge.
- R4: In the receive mode (bit 1 only) and in full-duplex (both bits), each finished word is written into the buffer entry at the position, and the position then increments. Status bits [7:4] always show the position.
- R5: In transmit-only mode (bit 0 only), the buffer is left unchanged and the position increments as each word finishes.
- R6: In receive mode, `mosi_o` is held at 0 while words shift.
- R7: When the number of finished words reaches the length, busy clears and `irq_o` pulses for exactly one cycle in the same cycle. Status bit 3 (pending) is set and stays set until a status write with bit 3 = 1.
- R8: Each read strobe at the data address returns the buffer entry at a separate read pointer, which then advances by one.
- R9: A status write with bit 0 = 1 clears the write pointer, the position and the read pointer, but only while busy is 0. Afterwards, status reads empty (bit 1) = 1, full (bit 2) = 0 and position 0.
- R10: The buffer is full (status bit 2) when 16 written words are unsent. After a 16-word burst, the busy, empty, full and position fields read exactly as they do just after a pointer clear.
- R11: Control writes are ignored while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe (advances the read pointer at the data address) |
| host_addr | input | 2 | Register address: 0 control, 1 data, 2 status |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Read data for `host_addr` |
| sclk_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| irq_o | output | 1 | One-cycle burst completion pulse |

## Verification
Register writes take effect at the clock edge that samples the strobe, so the bench reads status and control at the following falling edge. Busy rises one cycle after the write that makes a burst possible, and the bench therefore waits several cycles before reading it. Shifting runs for 16·`CLK_HALF` cycles per word. The bench waits for the interrupt under a cycle limit, then checks the words a serial slave model captured, the status byte and the read-back words against values it computes from the mode, the length and its own random data. The high time of the serial clock is measured in nanoseconds between its edges and compared with `CLK_HALF` clock periods.

// File: rtl/spim_pkg.sv
package spim_pkg;
   typedef enum logic [1:0] {
      RA_CTRL = 2'd0,
      RA_DATA = 2'd1,
      RA_STAT = 2'd2,
      RA_RSVD = 2'd3
   } reg_addr_e;

   localparam int unsigned CT_TXEN  = 0;
   localparam int unsigned CT_RXEN  = 1;
   localparam int unsigned ST_BUSY  = 0;
   localparam int unsigned ST_EMPTY = 1;
   localparam int unsigned ST_FULL  = 2;
   localparam int unsigned ST_PEND  = 3;
   localparam int unsigned FLD_LO   = 4;
   localparam int unsigned CMD_CLR  = 0;
   localparam int unsigned CMD_ACK  = 3;
endpackage

// File: rtl/spim_buf.sv
module spim_buf #(
   parameter int unsigned DW        = 8,
   parameter int unsigned DEPTH     = 16,
   parameter bit          RESET_EN  = 1'b1,
   localparam int unsigned AW       = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wa_en,
   input  logic [AW-1:0] wa_addr,
   input  logic [DW-1:0] wa_data,
   input  logic          wb_en,
   input  logic [AW-1:0] wb_addr,
   input  logic [DW-1:0] wb_data,
   input  logic [AW-1:0] ra_addr,
   output logic [DW-1:0] ra_data,
   input  logic [AW-1:0] rb_addr,
   output logic [DW-1:0] rb_data
);
   logic [DW-1:0] mem [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic hit_a, hit_b;
      assign hit_a = wa_en && (wa_addr == AW'(e));
      assign hit_b = wb_en && (wb_addr == AW'(e));
      if (RESET_EN) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     mem[e] <= '0;
            else if (hit_b) mem[e] <= wb_data;
            else if (hit_a) mem[e] <= wa_data;
         end
      end else begin : g_nrst
         always_ff @(posedge clk) begin
            if (hit_b)      mem[e] <= wb_data;
            else if (hit_a) mem[e] <= wa_data;
         end
      end
   end

   assign ra_data = mem[ra_addr];
   assign rb_data = mem[rb_addr];
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
   parameter int unsigned DW       = 8,
   parameter int unsigned CLK_HALF = 2,
   localparam int unsigned HCW     = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1,
   localparam int unsigned BW      = $clog2(DW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [DW-1:0] data_i,
   input  logic          miso_i,
   output logic          sclk_o,
   output logic          mosi_o,
   output logic          active_o,
   output logic          done_o,
   output logic [DW-1:0] rx_o
);
   logic [HCW-1:0] hcnt;
   logic [BW-1:0]  bitc;
   logic [DW-1:0]  tx_sr;
   logic           edge_due;

   assign edge_due = (hcnt == HCW'(CLK_HALF - 1));
   assign mosi_o   = tx_sr[DW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt     <= '0;
         bitc     <= '0;
         tx_sr    <= '0;
         rx_o     <= '0;
         sclk_o   <= 1'b0;
         active_o <= 1'b0;
         done_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (start_i && !active_o) begin
            active_o <= 1'b1;
            tx_sr    <= data_i;
            hcnt     <= '0;
            bitc     <= '0;
            sclk_o   <= 1'b0;
         end else if (active_o) begin
            if (edge_due) begin
               hcnt <= '0;
               if (!sclk_o) begin
                  sclk_o <= 1'b1;
                  rx_o   <= {rx_o[DW-2:0], miso_i};
               end else begin
                  sclk_o <= 1'b0;
                  if (bitc == BW'(DW - 1)) begin
                     active_o <= 1'b0;
                     done_o   <= 1'b1;
                  end else begin
                     bitc  <= bitc + 1'b1;
                     tx_sr <= {tx_sr[DW-2:0], 1'b0};
                  end
               end
            end else begin
               hcnt <= hcnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
   import spim_pkg::*;
#(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_we,
   input  logic          host_re,
   input  logic [1:0]    host_addr,
   input  logic [DW-1:0] host_wdata,
   output logic [DW-1:0] host_rdata,
   output logic          buf_wa_en,
   output logic [AW-1:0] buf_wa_addr,
   output logic [DW-1:0] buf_wa_data,
   output logic          buf_wb_en,
   output logic [AW-1:0] buf_wb_addr,
   output logic [DW-1:0] buf_wb_data,
   output logic [AW-1:0] buf_rd_addr,
   input  logic [DW-1:0] buf_rd_data,
   output logic [AW-1:0] buf_ls_addr,
   input  logic [DW-1:0] buf_ls_data,
   output logic          sh_start,
   output logic [DW-1:0] sh_data,
   input  logic          sh_active,
   input  logic          sh_done,
   input  logic [DW-1:0] sh_rx,
   output logic          busy_o,
   output logic          irq_o,
   output logic          tx_en_o,
   output logic          rx_en_o,
   output logic [CW-1:0] done_cnt_o,
   output logic [CW-1:0] len_o
);
   logic [DW-1:0] ctrl_q;
   logic [CW-1:0] wr_cnt, done_cnt, unsent;
   logic [AW-1:0] rd_ptr, len_fld;
   logic          busy, pend, irq;
   logic          wr_ctrl, wr_data, wr_stat, rd_data, last_word, go;

   assign tx_en_o    = ctrl_q[CT_TXEN];
   assign rx_en_o    = ctrl_q[CT_RXEN];
   assign len_fld    = ctrl_q[FLD_LO +: AW];
   assign len_o      = (len_fld == '0) ? CW'(DEPTH) : {1'b0, len_fld};
   assign unsent     = wr_cnt - done_cnt;
   assign done_cnt_o = done_cnt;
   assign busy_o     = busy;
   assign irq_o      = irq;

   assign wr_ctrl   = host_we && (host_addr == RA_CTRL) && !busy;
   assign wr_data   = host_we && (host_addr == RA_DATA) && (wr_cnt < len_o);
   assign wr_stat   = host_we && (host_addr == RA_STAT);
   assign rd_data   = host_re && (host_addr == RA_DATA);
   assign last_word = sh_done && ((done_cnt + 1'b1) == len_o);
   assign go        = !busy && (tx_en_o || rx_en_o) && (unsent != '0) && (done_cnt < len_o);

   assign buf_wa_en   = wr_data;
   assign buf_wa_addr = wr_cnt[AW-1:0];
   assign buf_wa_data = host_wdata;
   assign buf_wb_en   = sh_done && rx_en_o;
   assign buf_wb_addr = done_cnt[AW-1:0];
   assign buf_wb_data = sh_rx;
   assign buf_rd_addr = rd_ptr;
   assign buf_ls_addr = done_cnt[AW-1:0];

   assign sh_start = busy && !sh_active && !sh_done && (unsent != '0);
   assign sh_data  = tx_en_o ? buf_ls_data : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         wr_cnt   <= '0;
         done_cnt <= '0;
         rd_ptr   <= '0;
         busy     <= 1'b0;
         pend     <= 1'b0;
         irq      <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (wr_ctrl) ctrl_q <= host_wdata;
         if (wr_data) wr_cnt <= wr_cnt + 1'b1;
         if (rd_data) rd_ptr <= rd_ptr + 1'b1;
         if (go) busy <= 1'b1;
         if (sh_done) done_cnt <= done_cnt + 1'b1;
         if (wr_stat && host_wdata[CMD_ACK]) pend <= 1'b0;
         if (last_word) begin
            busy <= 1'b0;
            irq  <= 1'b1;
            pend <= 1'b1;
         end
         if (wr_stat && host_wdata[CMD_CLR] && !busy) begin
            wr_cnt   <= '0;
            done_cnt <= '0;
            rd_ptr   <= '0;
         end
      end
   end

   always_comb begin
      host_rdata = '0;
      unique case (host_addr)
         RA_CTRL: host_rdata = ctrl_q;
         RA_DATA: host_rdata = buf_rd_data;
         RA_STAT: begin
            host_rdata[ST_BUSY]        = busy;
            host_rdata[ST_EMPTY]       = (unsent == '0);
            host_rdata[ST_FULL]        = (unsent == CW'(DEPTH));
            host_rdata[ST_PEND]        = pend;
            host_rdata[FLD_LO +: AW]   = done_cnt[AW-1:0];
         end
         default: host_rdata = '0;
      endcase
   end
endmodule

// File: rtl/spim_burst.sv
module spim_burst #(
   parameter int unsigned DW        = 8,
   parameter int unsigned DEPTH     = 16,
   parameter int unsigned CLK_HALF  = 2,
   parameter bit          BUF_RESET = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_we,
   input  logic          host_re,
   input  logic [1:0]    host_addr,
   input  logic [DW-1:0] host_wdata,
   output logic [DW-1:0] host_rdata,
   output logic          sclk_o,
   output logic          mosi_o,
   input  logic          miso_i,
   output logic          irq_o
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned CW = AW + 1;

   if (DEPTH != (1 << AW)) begin : g_chk_depth
      $error("DEPTH must be a power of two");
   end
   if (DW < AW + 4) begin : g_chk_dw
      $error("DW too narrow for the status layout");
   end
   if (CLK_HALF < 1) begin : g_chk_half
      $error("CLK_HALF must be at least 1");
   end

   logic          wa_en, wb_en;
   logic [AW-1:0] wa_addr, wb_addr, rd_addr, ls_addr;
   logic [DW-1:0] wa_data, wb_data, rd_data, ls_data;
   logic          sh_start, sh_active, sh_done;
   logic [DW-1:0] sh_data, sh_rx;
   logic          busy, tx_en, rx_en;
   logic [CW-1:0] done_cnt, burst_len;

   spim_buf #(.DW(DW), .DEPTH(DEPTH), .RESET_EN(BUF_RESET)) i_buf (
      .clk(clk), .rst_n(rst_n),
      .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
      .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
      .ra_addr(rd_addr), .ra_data(rd_data),
      .rb_addr(ls_addr), .rb_data(ls_data)
   );

   spim_shift #(.DW(DW), .CLK_HALF(CLK_HALF)) i_shift (
      .clk(clk), .rst_n(rst_n),
      .start_i(sh_start), .data_i(sh_data), .miso_i(miso_i),
      .sclk_o(sclk_o), .mosi_o(mosi_o),
      .active_o(sh_active), .done_o(sh_done), .rx_o(sh_rx)
   );

   spim_ctrl #(.DW(DW), .DEPTH(DEPTH)) i_ctrl (
      .clk(clk), .rst_n(rst_n),
      .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .buf_wa_en(wa_en), .buf_wa_addr(wa_addr), .buf_wa_data(wa_data),
      .buf_wb_en(wb_en), .buf_wb_addr(wb_addr), .buf_wb_data(wb_data),
      .buf_rd_addr(rd_addr), .buf_rd_data(rd_data),
      .buf_ls_addr(ls_addr), .buf_ls_data(ls_data),
      .sh_start(sh_start), .sh_data(sh_data),
      .sh_active(sh_active), .sh_done(sh_done), .sh_rx(sh_rx),
      .busy_o(busy), .irq_o(irq_o), .tx_en_o(tx_en), .rx_en_o(rx_en),
      .done_cnt_o(done_cnt), .len_o(burst_len)
   );
endmodule

// File: rtl/spim_burst_chk.sv
module spim_burst_chk #(
   parameter int unsigned DW = 8,
   parameter int unsigned CW = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          host_we,
   input logic [1:0]    host_addr,
   input logic [DW-1:0] host_wdata,
   input logic          sclk_o,
   input logic          mosi_o,
   input logic          irq_o,
   input logic          busy,
   input logic          tx_en,
   input logic          rx_en,
   input logic          sh_active,
   input logic [CW-1:0] done_cnt,
   input logic [CW-1:0] burst_len
);
   // R7: the completion pulse lasts one cycle
   a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);
   // R7: busy ends together with the pulse
   a_r7_busy_end_irq: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> irq_o);
   // R1: serial clock idle outside a burst
   a_r1_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk_o);
   // R3: data out holds while the serial clock is high
   a_r3_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_o |-> $stable(mosi_o));
   // R6: receive mode keeps data out low
   a_r6_rx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_active && rx_en && !tx_en) |-> !mosi_o);
   // R2: position never passes the length during a burst
   a_r2_within_len: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (done_cnt < burst_len));
   // R9: idle pointer clear zeroes the position
   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && host_addr == 2'd2 && host_wdata[0] && !busy) |=> (done_cnt == '0));
endmodule

bind spim_burst spim_burst_chk #(.DW(DW), .CW(CW)) i_chk (
   .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
   .host_wdata(host_wdata), .sclk_o(sclk_o), .mosi_o(mosi_o), .irq_o(irq_o),
   .busy(busy), .tx_en(tx_en), .rx_en(rx_en), .sh_active(sh_active),
   .done_cnt(done_cnt), .burst_len(burst_len)
);

// File: tb/test_spim_burst.sv
module test_spim_burst;
   localparam int HALF = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_we = 1'b0, host_re = 1'b0;
   logic [1:0] host_addr = 2'd0;
   logic [7:0] host_wdata = 8'd0;
   logic [7:0] host_rdata;
   logic       sclk_o, mosi_o, miso_i, irq_o;

   int n_run = 0, n_fail = 0;
   bit done_flag = 0;

   always #4 clk = ~clk;

   spim_burst #(.DW(8), .DEPTH(16), .CLK_HALF(HALF)) i_spim_burst (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i), .irq_o(irq_o)
   );

   // serial slave model
   logic [7:0] s_tx [32];
   logic [7:0] s_rx [32];
   logic [7:0] s_sh = 8'd0;
   int s_bit = 0, s_word = 0;
   time t_rise = 0, hi_time = 0;
   assign miso_i = s_tx[s_word % 32][7 - s_bit];
   always @(posedge sclk_o) begin
      s_sh = {s_sh[6:0], mosi_o};
      t_rise = $time;
   end
   always @(negedge sclk_o) begin
      hi_time = $time - t_rise;
      if (s_bit == 7) begin
         s_rx[s_word % 32] = s_sh;
         s_word = s_word + 1;
         s_bit = 0;
      end else s_bit = s_bit + 1;
   end

   int irq_cnt = 0;
   always @(posedge clk) if (irq_o) irq_cnt <= irq_cnt + 1;

   logic [7:0] tx_w [16];

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      host_re = 1'b1; host_addr = a;
      #1 d = host_rdata;
      @(negedge clk);
      host_re = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   function automatic logic [7:0] st(input bit b, input bit e, input bit f, input bit p, input int pos);
      return {4'(pos), p, f, e, b};
   endfunction

   task automatic slave_reset();
      s_bit = 0; s_word = 0;
      for (int i = 0; i < 32; i++) s_tx[i] = 8'($urandom);
   endtask

   task automatic wait_irq(input string tag);
      int k;
      k = 0;
      while (irq_cnt == 0 && k < 5000) begin @(negedge clk); k++; end
      check(irq_cnt != 0, tag, 0, 1);
      idle(3);
   endtask

   task automatic run_burst(input logic [1:0] mode, input int cnt, input int nw);
      int len, bad;
      logic [7:0] d;
      len = (cnt == 0) ? 16 : cnt;
      wr(2'd2, 8'h09);
      slave_reset();
      irq_cnt = 0;
      wr(2'd0, {4'(cnt), 2'b00, mode});
      for (int i = 0; i < nw; i++) begin
         tx_w[i % 16] = 8'($urandom);
         wr(2'd1, tx_w[i % 16]);
      end
      wait_irq("R7 completion");
      check(irq_cnt == 1, "R7 single pulse", irq_cnt, 1);
      check(s_word == len, "R2 words sent", s_word, len);
      bad = 0;
      for (int i = 0; i < len; i++)
         if (s_rx[i] != (mode[0] ? tx_w[i] : 8'h00)) bad++;
      check(bad == 0, mode[0] ? "R3 mosi words" : "R6 rx-only mosi", bad, 0);
      rd(2'd2, d);
      check(d == st(0, 1, 0, 1, len % 16), "R4 R10 status after burst", d, st(0, 1, 0, 1, len % 16));
      bad = 0;
      for (int i = 0; i < len; i++) begin
         rd(2'd1, d);
         if (d != (mode[1] ? s_tx[i] : tx_w[i])) bad++;
      end
      check(bad == 0, mode[1] ? "R4 R8 in-place readback" : "R5 R8 tx-only readback", bad, 0);
   endtask

   initial begin
      #(8 * 150000);
      if (!done_flag) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      void'($urandom(32'd2024));
      slave_reset();
      idle(3);
      rst_n = 1'b1;
      idle(2);
      rd(2'd2, d);
      check(d == 8'h02, "R9 reset status", d, 8'h02);
      rd(2'd0, d);
      check(d == 8'h00, "R11 reset control", d, 8'h00);

      // R1: data present, no enable -> no burst
      wr(2'd0, 8'h40);
      for (int i = 0; i < 4; i++) begin tx_w[i] = 8'($urandom); wr(2'd1, tx_w[i]); end
      idle(40);
      rd(2'd2, d);
      check(d == 8'h00 && s_word == 0, "R1 no start when disabled", d, 8'h00);
      irq_cnt = 0;
      wr(2'd0, 8'h43);
      idle(4);
      rd(2'd2, d);
      check(d[0] == 1'b1, "R1 start on enable", d, 1);
      wait_irq("R1 burst finish");
      check(hi_time == 8 * HALF, "R3 sclk high time", int'(hi_time), 8 * HALF);

      // R1 wait on empty, R11 and R9 while busy
      wr(2'd2, 8'h09);
      slave_reset();
      irq_cnt = 0;
      wr(2'd0, 8'h33);
      tx_w[0] = 8'($urandom); wr(2'd1, tx_w[0]);
      idle(200);
      rd(2'd2, d);
      check(d == st(1, 1, 0, 0, 1), "R1 waits when empty", d, st(1, 1, 0, 0, 1));
      check(s_word == 1, "R1 one word so far", s_word, 1);
      wr(2'd0, 8'h51);
      rd(2'd0, d);
      check(d == 8'h33, "R11 control frozen", d, 8'h33);
      wr(2'd2, 8'h01);
      rd(2'd2, d);
      check(d[7:4] == 4'd1, "R9 clear ignored while busy", d[7:4], 1);
      for (int i = 1; i < 3; i++) begin tx_w[i] = 8'($urandom); wr(2'd1, tx_w[i]); end
      wait_irq("R1 resumes");
      rd(2'd2, d);
      check(d == st(0, 1, 0, 1, 3), "R4 position 3", d, st(0, 1, 0, 1, 3));
      wr(2'd2, 8'h08);
      rd(2'd2, d);
      check(d == st(0, 1, 0, 0, 3), "R7 pending cleared", d, st(0, 1, 0, 0, 3));

      // R10 full buffer and 16-word burst
      wr(2'd2, 8'h09);
      rd(2'd2, d);
      check(d == 8'h02, "R9 status after clear", d, 8'h02);
      slave_reset();
      irq_cnt = 0;
      wr(2'd0, 8'h00);
      for (int i = 0; i < 16; i++) begin tx_w[i] = 8'($urandom); wr(2'd1, tx_w[i]); end
      rd(2'd2, d);
      check(d == 8'h04, "R10 full flag", d, 8'h04);
      wr(2'd1, 8'hA5);
      rd(2'd2, d);
      check(d == 8'h04, "R2 extra word dropped", d, 8'h04);
      wr(2'd0, 8'h03);
      wait_irq("R10 burst of 16");
      check(s_word == 16, "R2 zero means 16", s_word, 16);
      wr(2'd2, 8'h08);
      rd(2'd2, d);
      check(d == 8'h02, "R10 same as cleared", d, 8'h02);

      // random bursts
      for (int b = 0; b < 12; b++) begin
         int cnt, len, nw;
         logic [1:0] mode;
         mode = 2'(1 + ($urandom % 3));
         cnt = $urandom % 16;
         len = (cnt == 0) ? 16 : cnt;
         nw = len + ($urandom % 3);
         if (nw > 16) nw = 16;
         run_burst(mode, cnt, nw);
      end

      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule